// File: doc/BRIEF.md
# Byte-Oriented I2C Bus Master

This block is a register-programmed I2C master that moves one byte per software action. A host reaches it through a byte-wide register port with six word-spaced slots. Storing a byte into the data slot launches a bus phase. The first store after the block has no transfer open goes out as a START followed by the 7-bit target address and the R/W bit. Later stores go out as plain data bytes. In receive mode, each read of the data slot returns the byte already held and asks the bus for the next one.

The bit-level sequencer drives SCL and SDA only as open-drain pull-downs. It runs from a quarter-bit tick derived from the divider register. Each finished byte is reported through sticky completion flags in the status register. A level interrupt is the AND of those flags with two control bits. Turning the enable bit off performs a soft reset that keeps only the own-address register.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status (offset 0x0C) reads 0x81, every other register reads 0x00, no transfer is open, and `irq` is low.
- R2: The register offsets are own-address 0x00, divider 0x04, control 0x08, status 0x0C and data 0x10. Writes are masked with 0xFE, 0x3F, 0xFC, 0xED and 0xFF respectively. Any other offset, including 0x14, reads 0x00 and ignores writes.
- R3: While the control enable bit (bit 7) is 0, writes to the data register leave it unchanged and cause no bus activity.
- R4: A control write that clears bit 7 while it is set is a soft reset. Every register returns to its R1 value except own-address, and the other bits of that write are dropped.
- R5: Bus busy (status bit 5) follows every control write of the master bit (control bit 5). Clearing the master bit while the block holds the bus issues a STOP.
- R6: With enable and master set, a data write with no transfer open sends START plus the byte. A data write during an open transfer sends the byte with no START. On an ACK, status bit 0 clears and bits 7 and 1 set.
- R7: A NACK sets status bit 0 and leaves bit 1 clear. A NACK on a data byte also issues a STOP, and the next data write then goes out as an address.
- R8: A status write clears the interrupt flag (bit 1) and the arbitration flag (bit 4). `irq` is high exactly when enable, interrupt enable (control bit 6) and the interrupt flag are all set.
- R9: With master set and direction (control bit 4) clear, a data read returns the held byte and starts a receive. The received byte then lands in the data register and sets status bits 7 and 1. The master ACKs the byte unless control bit 3 is set.
- R10: While a receive is in flight, the data register reads 0xFF.
- R11: Writing control bit 2 as 1 with a transfer open closes that transfer and clears bit 2 again. The next data write then produces a repeated START with no STOP before it.
- R12: The SCL high time of every bit is (divider + 1) × 8 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The bench attaches a bus slave model and aims at the points where the byte sequencing can slip. It checks that a second data write sends no fresh START, and that a design which always prefixed a START would raise the slave's start count. A NACKed data byte must end in a STOP and must turn the next write back into an address; an address NACK must not raise the interrupt flag, as a controller that treated every byte the same would. The bench also checks the 0xFF in-flight read, the self-clearing repeated-start bit that must not emit a STOP, and the soft reset that must keep own-address while a sloppy one would zero it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {CMD_ADDR, CMD_TX, CMD_RX, CMD_STOP} cmd_e;

  localparam int DIV_W = 6;

  localparam int OFS_OWN = 'h00;
  localparam int OFS_DIV = 'h04;
  localparam int OFS_CTL = 'h08;
  localparam int OFS_STS = 'h0C;
  localparam int OFS_DAT = 'h10;

  localparam logic [7:0] MASK_OWN  = 8'hFE;
  localparam logic [7:0] MASK_CTL  = 8'hFC;
  localparam logic [7:0] MASK_STS  = 8'hED;
  localparam logic [7:0] STS_RESET = 8'h81;
  localparam logic [7:0] NO_CYCLE  = 8'hFF;

  localparam int C_EN = 7, C_IEN = 6, C_MSTA = 5, C_MTX = 4, C_TXAK = 3, C_RSTA = 2;
  localparam int S_MCF = 7, S_MBB = 5, S_MAL = 4, S_MIF = 1, S_RXAK = 0;
endpackage

// File: rtl/i2cm_tick_gen.sv
module i2cm_tick_gen #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  localparam int CNT_W = DW + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {div, 2'b11};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R12
endmodule

// File: rtl/i2cm_bit_engine.sv
module i2cm_bit_engine
  import i2cm_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic [DW-1:0] div,
  input  logic          go,
  input  cmd_e          kind_in,
  input  logic [7:0]    tx_byte,
  input  logic          ack_drive,
  input  logic          sda_in,
  output logic          busy,
  output logic          holding,
  output logic          done,
  output logic          nack,
  output logic [7:0]    rx_byte,
  output logic          scl_low,
  output logic          sda_low
);
  typedef enum logic [2:0] {E_IDLE, E_START, E_BIT, E_END, E_STOP} est_e;

  est_e       state;
  cmd_e       kind;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       sda_s1, sda_s2, tick;

  i2cm_tick_gen #(.DW(DW)) u_tick (
    .clk(clk), .rst(rst || abort), .run(state != E_IDLE), .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state   <= E_IDLE;
      kind    <= CMD_ADDR;
      q       <= '0;
      bitn    <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      nack    <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == E_IDLE) begin
        if (go) begin
          kind  <= kind_in;
          shreg <= tx_byte;
          q     <= '0;
          bitn  <= '0;
          nack  <= 1'b0;
          state <= (kind_in == CMD_ADDR) ? E_START :
                   (kind_in == CMD_STOP) ? E_STOP : E_BIT;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        case (state)
          E_START: begin
            case (q)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin
                scl_low <= 1'b1;
                state   <= E_BIT;
              end
            endcase
          end
          E_BIT: begin
            case (q)
              2'd0: begin
                scl_low <= 1'b1;
                if (bitn < 4'd8) sda_low <= (kind == CMD_RX) ? 1'b0 : ~shreg[7];
                else             sda_low <= (kind == CMD_RX) ? ack_drive : 1'b0;
              end
              2'd2: scl_low <= 1'b0;
              2'd3: begin
                if (bitn < 4'd8) begin
                  shreg <= {shreg[6:0], sda_s2};
                  bitn  <= bitn + 1'b1;
                end else begin
                  nack  <= sda_s2;
                  state <= E_END;
                end
              end
              default: ;
            endcase
          end
          E_END: begin
            scl_low <= 1'b1;
            q       <= '0;
            if (kind == CMD_TX && nack) begin
              state <= E_STOP;
            end else begin
              state <= E_IDLE;
              done  <= 1'b1;
            end
          end
          E_STOP: begin
            case (q)
              2'd0: begin
                scl_low <= 1'b1;
                sda_low <= 1'b1;
              end
              2'd1: scl_low <= 1'b0;
              2'd3: begin
                sda_low <= 1'b0;
                state   <= E_IDLE;
                done    <= 1'b1;
              end
              default: ;
            endcase
          end
          default: state <= E_IDLE;
        endcase
      end
    end
  end

  assign busy    = (state != E_IDLE);
  assign holding = busy || scl_low;
  assign rx_byte = shreg;

  // SDA may only move under a high SCL as part of a START or STOP
  AST_SDA_STILL_UNDER_SCL: assert property (@(posedge clk) disable iff (rst)
    (!scl_low && $past(!scl_low) && !$past(abort) && (sda_low != $past(sda_low)))
      |-> ($past(state) == E_START || $past(state) == E_STOP)); // R6
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sda_in
);
  localparam logic [ADDR_W-1:0] A_OWN = ADDR_W'(OFS_OWN);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);

  logic [7:0]       own_q, ctl_q, sts_q, dat_q, cyc_q, pend_byte_q;
  logic [DIV_W-1:0] div_q;
  cmd_e             pend_kind_q;
  logic             stop_pend_q;

  logic [7:0]       own_n, ctl_n, sts_n, dat_n, cyc_n;
  logic [DIV_W-1:0] div_n;
  logic             stop_n, launch;
  cmd_e             launch_kind;

  logic       eng_busy, eng_hold, eng_done, eng_nack;
  logic [7:0] eng_rx;

  logic wr_own, wr_div, wr_ctl, wr_sts, wr_dat, rd_dat, soft_rst;
  assign wr_own   = wr_en && addr == A_OWN;
  assign wr_div   = wr_en && addr == A_DIV;
  assign wr_ctl   = wr_en && addr == A_CTL;
  assign wr_sts   = wr_en && addr == A_STS;
  assign wr_dat   = wr_en && addr == A_DAT;
  assign rd_dat   = rd_en && addr == A_DAT;
  assign soft_rst = wr_ctl && ctl_q[C_EN] && !wdata[C_EN];

  i2cm_bit_engine #(.DW(DIV_W)) u_engine (
    .clk(clk), .rst(rst), .abort(soft_rst), .div(div_q),
    .go(launch), .kind_in(launch_kind), .tx_byte(wdata), .ack_drive(~ctl_q[C_TXAK]),
    .sda_in(sda_in), .busy(eng_busy), .holding(eng_hold), .done(eng_done),
    .nack(eng_nack), .rx_byte(eng_rx), .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  always_comb begin
    own_n = own_q; div_n = div_q; ctl_n = ctl_q; sts_n = sts_q;
    dat_n = dat_q; cyc_n = cyc_q; stop_n = stop_pend_q;
    launch = 1'b0; launch_kind = CMD_STOP;

    if (eng_done) begin
      case (pend_kind_q)
        CMD_ADDR: begin
          if (eng_nack) sts_n[S_RXAK] = 1'b1;
          else begin
            sts_n[S_RXAK] = 1'b0; sts_n[S_MCF] = 1'b1; sts_n[S_MIF] = 1'b1;
            cyc_n = pend_byte_q;
          end
        end
        CMD_TX: begin
          if (eng_nack) begin
            sts_n[S_RXAK] = 1'b1;
            cyc_n = NO_CYCLE;
          end else begin
            sts_n[S_RXAK] = 1'b0; sts_n[S_MCF] = 1'b1; sts_n[S_MIF] = 1'b1;
          end
        end
        CMD_RX: begin
          dat_n = eng_rx;
          sts_n[S_MCF] = 1'b1; sts_n[S_MIF] = 1'b1;
        end
        default: ;
      endcase
    end

    if (wr_own) own_n = wdata & MASK_OWN;
    if (wr_div) div_n = wdata[DIV_W-1:0];
    if (wr_sts) sts_n = wdata & MASK_STS;
    if (wr_ctl && !soft_rst) begin
      ctl_n = wdata & MASK_CTL;
      sts_n[S_MBB] = wdata[C_MSTA];
      if (!wdata[C_MSTA]) begin
        cyc_n = NO_CYCLE;
        if (eng_hold) stop_n = 1'b1;
      end else if (wdata[C_RSTA] && cyc_q != NO_CYCLE) begin
        cyc_n = NO_CYCLE;
        ctl_n[C_RSTA] = 1'b0;
      end
    end
    if (wr_dat && ctl_q[C_EN]) begin
      dat_n = wdata;
      if (ctl_q[C_MSTA] && !eng_busy) begin
        launch = 1'b1;
        launch_kind = (cyc_q == NO_CYCLE) ? CMD_ADDR : CMD_TX;
      end
    end
    if (rd_dat && ctl_q[C_MSTA] && !ctl_q[C_MTX] && !eng_busy) begin
      launch = 1'b1;
      launch_kind = CMD_RX;
      dat_n = NO_CYCLE;
    end
    if (!launch && stop_pend_q && !eng_busy) begin
      launch = 1'b1;
      launch_kind = CMD_STOP;
      stop_n = 1'b0;
    end
    if (soft_rst) begin
      own_n = own_q; div_n = '0; ctl_n = '0; sts_n = STS_RESET;
      dat_n = '0; cyc_n = NO_CYCLE; stop_n = 1'b0; launch = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0; div_q <= '0; ctl_q <= '0; sts_q <= STS_RESET; dat_q <= '0;
      cyc_q <= NO_CYCLE; pend_byte_q <= '0; pend_kind_q <= CMD_STOP;
      stop_pend_q <= 1'b0; irq <= 1'b0; rdata <= '0;
    end else begin
      own_q <= own_n; div_q <= div_n; ctl_q <= ctl_n; sts_q <= sts_n;
      dat_q <= dat_n; cyc_q <= cyc_n; stop_pend_q <= stop_n;
      irq <= ctl_n[C_EN] && ctl_n[C_IEN] && sts_n[S_MIF];
      if (launch) begin
        pend_kind_q <= launch_kind;
        pend_byte_q <= wdata;
      end
      if (rd_en) begin
        case (addr)
          A_OWN:   rdata <= own_q;
          A_DIV:   rdata <= {{(8-DIV_W){1'b0}}, div_q};
          A_CTL:   rdata <= ctl_q;
          A_STS:   rdata <= sts_q;
          A_DAT:   rdata <= dat_q;
          default: rdata <= '0;
        endcase
      end
    end
  end

  AST_STS_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    wr_sts |=> (!sts_q[S_MIF] && !sts_q[S_MAL])); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctl_q[C_EN] && ctl_q[C_IEN] && sts_q[S_MIF])); // R8
  AST_DATA_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && !ctl_q[C_EN] && !eng_done && !rd_dat) |=> $stable(dat_q)); // R3
  AST_SOFT_RESET_KEEPS_OWN: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (ctl_q == 8'h00 && sts_q == STS_RESET && $stable(own_q))); // R4
  AST_BUSY_FOLLOWS_MASTER: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !soft_rst) |=> (sts_q[S_MBB] == $past(wdata[C_MSTA]))); // R5
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq, dut_scl_low, dut_sda_low;
  logic slv_sda_low;
  logic scl, sda;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign scl = !dut_scl_low;
  assign sda = !(dut_sda_low || slv_sda_low);

  i2c_byte_master #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .scl_drive_low(dut_scl_low), .sda_drive_low(dut_sda_low),
    .sda_in(sda)
  );

  // bus slave model at 7-bit address 0x50; NACKs data byte 0xEE
  localparam logic [6:0] SLV = 7'h50;
  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_WR, M_RD} smode_e;
  smode_e mode;
  logic p_scl, p_sda, armed, ack_addr, mack;
  logic [3:0] bitc;
  logic [7:0] shr, rd_byte, got_byte;
  int start_cnt, stop_cnt, hi_run, last_hi;

  always @(posedge clk) begin
    p_scl <= scl;
    p_sda <= sda;
    hi_run <= scl ? hi_run + 1 : 0;
    if (rst) begin
      mode <= M_IDLE; armed <= 0; ack_addr <= 0; mack <= 0; bitc <= 0; shr <= 0;
      rd_byte <= 8'hA5; got_byte <= 0; slv_sda_low <= 0;
      start_cnt <= 0; stop_cnt <= 0; last_hi <= 0;
    end else if (p_scl && scl && p_sda && !sda) begin
      start_cnt <= start_cnt + 1; mode <= M_ADDR; armed <= 0; bitc <= 0; slv_sda_low <= 0;
    end else if (p_scl && scl && !p_sda && sda) begin
      stop_cnt <= stop_cnt + 1; mode <= M_IDLE; slv_sda_low <= 0;
    end else if (!p_scl && scl) begin
      if (bitc < 8) shr <= {shr[6:0], sda};
      else mack <= !sda;
    end else if (p_scl && !scl) begin
      last_hi <= hi_run;
      if (!armed) armed <= 1;
      else if (bitc == 7) begin
        bitc <= 8;
        case (mode)
          M_ADDR: begin ack_addr <= (shr[7:1] == SLV); slv_sda_low <= (shr[7:1] == SLV); end
          M_WR:   begin got_byte <= shr; slv_sda_low <= (shr != 8'hEE); end
          default: slv_sda_low <= 0;
        endcase
      end else if (bitc == 8) begin
        bitc <= 0;
        case (mode)
          M_ADDR: begin
            if (!ack_addr) begin mode <= M_IDLE; slv_sda_low <= 0; end
            else if (shr[0]) begin mode <= M_RD; slv_sda_low <= !rd_byte[7]; end
            else begin mode <= M_WR; slv_sda_low <= 0; end
          end
          M_RD: begin
            if (mack) begin rd_byte <= ~rd_byte; slv_sda_low <= rd_byte[7]; end
            else begin mode <= M_IDLE; slv_sda_low <= 0; end
          end
          default: slv_sda_low <= 0;
        endcase
      end else begin
        bitc <= bitc + 1;
        if (mode == M_RD) slv_sda_low <= !rd_byte[3'd6 - bitc[2:0]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic wait_mif(input string tag);
    logic [7:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(5'h0C, s);
      if (s[1]) return;
    end
    chk({tag, " completion flag timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(5'h0C, d); chk("R1 status", d, 8'h81);
    rd(5'h08, d); chk("R1 control", d, 8'h00);
    rd(5'h00, d); chk("R1 own", d, 8'h00);
    rd(5'h10, d); chk("R1 data", d, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    wr(5'h00, 8'hFF); rd(5'h00, d); chk("R2 own mask", d, 8'hFE);
    wr(5'h04, 8'hFF); rd(5'h04, d); chk("R2 divider mask", d, 8'h3F);
    wr(5'h14, 8'hAA); rd(5'h14, d); chk("R2 offset 0x14", d, 8'h00);
    rd(5'h1C, d); chk("R2 unmapped", d, 8'h00);
    wr(5'h08, 8'h83); rd(5'h08, d); chk("R2 control mask", d, 8'h80);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    wr(5'h08, 8'h40);
    rd(5'h08, d); chk("R4 control cleared", d, 8'h00);
    rd(5'h04, d); chk("R4 divider cleared", d, 8'h00);
    rd(5'h00, d); chk("R4 own kept", d, 8'hFE);
    rd(5'h0C, d); chk("R4 status", d, 8'h81);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int s0 = start_cnt;
    wr(5'h10, 8'h77);
    repeat (100) @(negedge clk);
    rd(5'h10, d); chk("R3 data ignored", d, 8'h00);
    chk("R3 no bus start", start_cnt, s0);
  endtask

  task automatic t_write();
    logic [7:0] d;
    int s0;
    wr(5'h04, 8'h01);
    wr(5'h08, 8'hF0);
    rd(5'h0C, d); chk("R5 busy set", d, 8'hA1);
    s0 = start_cnt;
    wr(5'h10, 8'hA0); wait_mif("R6");
    rd(5'h0C, d); chk("R6 address ack status", d, 8'hA2);
    chk("R6 start sent", start_cnt, s0 + 1);
    chk("R8 irq raised", irq, 1);
    wr(5'h0C, 8'h20);
    chk("R8 irq lowered", irq, 0);
    rd(5'h0C, d); chk("R8 status after clear", d, 8'h20);
    wr(5'h10, 8'h3C); wait_mif("R6");
    chk("R6 data byte", got_byte, 8'h3C);
    chk("R6 no second start", start_cnt, s0 + 1);
    chk("R12 SCL high time", last_hi, 16);
    wr(5'h0C, 8'h20);
  endtask

  task automatic t_data_nack();
    logic [7:0] d;
    int p0 = stop_cnt, s0 = start_cnt;
    wr(5'h10, 8'hEE);
    repeat (700) @(negedge clk);
    rd(5'h0C, d); chk("R7 data nack flags", d[1:0], 2'b01);
    chk("R7 stop after data nack", stop_cnt, p0 + 1);
    wr(5'h10, 8'hA0); wait_mif("R7");
    chk("R7 next write is address", start_cnt, s0 + 1);
    rd(5'h0C, d); chk("R7 address acked", d[1:0], 2'b10);
    wr(5'h0C, 8'h20);
  endtask

  task automatic t_rsta();
    logic [7:0] d;
    int p0, s0;
    wr(5'h08, 8'hF4);
    rd(5'h08, d); chk("R11 restart bit self clears", d, 8'hF0);
    p0 = stop_cnt; s0 = start_cnt;
    wr(5'h10, 8'hA0); wait_mif("R11");
    chk("R11 repeated start", start_cnt, s0 + 1);
    chk("R11 no stop", stop_cnt, p0);
    wr(5'h0C, 8'h20);
  endtask

  task automatic t_addr_nack();
    logic [7:0] d;
    wr(5'h08, 8'hF4);
    wr(5'h10, 8'h90);
    repeat (700) @(negedge clk);
    rd(5'h0C, d); chk("R7 address nack flags", d[1:0], 2'b01);
  endtask

  task automatic t_read();
    logic [7:0] d;
    int p0;
    wr(5'h10, 8'hA1); wait_mif("R9");
    wr(5'h0C, 8'h20);
    wr(5'h08, 8'hE0);
    rd(5'h10, d); chk("R9 read returns held byte", d, 8'hA1);
    rd(5'h10, d); chk("R10 in-flight reads FF", d, 8'hFF);
    wait_mif("R9");
    wr(5'h0C, 8'h20);
    wr(5'h08, 8'hE8);
    rd(5'h10, d); chk("R9 first received byte", d, 8'hA5);
    wait_mif("R9");
    wr(5'h0C, 8'h20);
    p0 = stop_cnt;
    wr(5'h08, 8'hC0);
    rd(5'h0C, d); chk("R5 busy cleared", d, 8'h00);
    repeat (200) @(negedge clk);
    chk("R5 stop on master clear", stop_cnt, p0 + 1);
    rd(5'h10, d); chk("R9 second byte after ACK", d, 8'h5A);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_masks();
    t_soft_reset();
    t_disabled();
    wr(5'h08, 8'h80);
    t_write();
    t_data_nack();
    t_rsta();
    t_addr_nack();
    t_read();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule